// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. Two 16-bit operands are widened to 17 bits, either sign-extended or zero-extended, and multiplied. The 34-bit product goes through one dedicated 40-bit adder into one of two independent 40-bit accumulators. The select input picks the accumulator. The whole multiply-add finishes in one clock, with no pipeline stage between the multiplier and the accumulator.

Each accumulator keeps 8 guard bits above the 32-bit product range, so long dot-product, convolution or correlation sums can grow without wrapping. A 16-bit holding register can stand in for the second multiplier operand, so a coefficient can be loaded once and reused. Each accumulator has its own sticky overflow flag. The flag records any multiply-add or multiply-subtract whose 40-bit result left the signed range, and only the clear operation resets it.

Top module: `dual_acc_mac`

## Requirements
- R1: After reset, both accumulators, both overflow flags and the holding register are zero. A multiply that uses the holding register straight after reset therefore yields zero.
- R2: Opcode 2 (multiply) writes the product of the two widened operands into the selected accumulator (`acc_sel` 0 = first, 1 = second). The result is visible after the next rising clock edge.
- R3: With `signed_mode` at 1 both operands are sign-extended to 17 bits. With it at 0 they are zero-extended, so 0xFFFF counts as 65535.
- R4: Opcode 3 (multiply-add) adds the product to the selected accumulator in one cycle. The unselected accumulator and its flag do not change.
- R5: Opcode 4 (multiply-subtract) subtracts the product from the selected accumulator in one cycle.
- R6: Opcode 6 loads `opa` into the holding register and leaves the accumulators unchanged. While `use_t` is 1, the holding register replaces `opb` as the second multiplier operand, and `opb` has no effect.
- R7: Opcode 5 loads the selected accumulator with `opa`, widened as in R3 and then sign-extended to 40 bits.
- R8: Opcode 1 (clear) zeroes the selected accumulator and its overflow flag in one cycle.
- R9: An accumulator's overflow flag sets when a multiply-add or multiply-subtract result leaves the signed 40-bit range. The stored value then wraps modulo 2^40. The flag stays set until a clear of that accumulator, and sums below 2^39 never set it.
- R10: Opcodes 0 and 7 change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code (0/7 idle, 1 clear, 2 multiply, 3 multiply-add, 4 multiply-subtract, 5 load accumulator, 6 load holding register) |
| acc_sel | input | 1 | Target accumulator: 0 first, 1 second |
| signed_mode | input | 1 | 1 sign-extends operands, 0 zero-extends |
| use_t | input | 1 | 1 takes the second multiplier operand from the holding register |
| opa | input | 16 | First operand; also load data for opcodes 5 and 6 |
| opb | input | 16 | Second operand when `use_t` is 0 |
| acc_a | output | 40 | First accumulator |
| acc_b | output | 40 | Second accumulator |
| ovf_a | output | 1 | Sticky overflow flag of the first accumulator |
| ovf_b | output | 1 | Sticky overflow flag of the second accumulator |

## Verification
Every accumulator and flag is a port, so any wrong register state shows up one edge after the operation that caused it. The one exception is the holding register, which is internal. A corrupted holding register shows only at the next multiply with `use_t` set, so the bench runs such a multiply directly after each load. A wrong overflow decision shows in the flag at once. A flag that fails to stay set shows on any later idle or multiply-add cycle. The long run of full-scale unsigned multiply-adds steps across the 2^39 boundary one product at a time. That run pins the overflow edge to one particular cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_CLR  = 3'd1,
      OP_MPY  = 3'd2,
      OP_MAC  = 3'd3,
      OP_MSU  = 3'd4,
      OP_LDA  = 3'd5,
      OP_LDT  = 3'd6,
      OP_IDLE = 3'd7
   } mac_op_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_ZERO = 2'd1,
      ACT_SET  = 2'd2,
      ACT_SUM  = 2'd3
   } acc_act_e;

   localparam int unsigned ACC_COUNT = 2;

endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
   parameter int unsigned IN_W = 16
) (
   input  logic [IN_W-1:0] din,
   input  logic            sgn,
   output logic [IN_W:0]   dout
);
   always_comb begin
      dout = sgn ? {din[IN_W-1], din} : {1'b0, din};
   end
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
   parameter int unsigned EXT_W = 17
) (
   input  logic signed [EXT_W-1:0]   mcand,
   input  logic signed [EXT_W-1:0]   mplier,
   output logic signed [2*EXT_W-1:0] prod
);
   always_comb begin
      prod = mcand * mplier;
   end
endmodule

// File: rtl/mac_acc_adder.sv
module mac_acc_adder #(
   parameter int unsigned W = 40
) (
   input  logic [W-1:0] base,
   input  logic [W-1:0] addend,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         ovf
);
   logic sa, sb, sr;

   always_comb begin
      sum = sub ? (base - addend) : (base + addend);
      sa  = base[W-1];
      sb  = addend[W-1];
      sr  = sum[W-1];
      if (sub) ovf = (sa != sb) && (sr != sa);
      else     ovf = (sa == sb) && (sr != sa);
   end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
   import mac_pkg::*;
#(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned NUM   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  acc_act_e                  act [NUM],
   input  logic [ACC_W-1:0]          set_val,
   input  logic [ACC_W-1:0]          sum_val,
   input  logic                      sum_ovf,
   output logic [NUM-1:0][ACC_W-1:0] acc_q,
   output logic [NUM-1:0]            ovf_q
);
   for (genvar g = 0; g < NUM; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_q[g] <= '0;
            ovf_q[g] <= 1'b0;
         end else begin
            unique case (act[g])
               ACT_ZERO: begin
                  acc_q[g] <= '0;
                  ovf_q[g] <= 1'b0;
               end
               ACT_SET:  acc_q[g] <= set_val;
               ACT_SUM: begin
                  acc_q[g] <= sum_val;
                  ovf_q[g] <= ovf_q[g] | sum_ovf;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
   import mac_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ACC_W  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op,
   input  logic              acc_sel,
   input  logic              signed_mode,
   input  logic              use_t,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [ACC_W-1:0]  acc_a,
   output logic [ACC_W-1:0]  acc_b,
   output logic              ovf_a,
   output logic              ovf_b
);
   localparam int unsigned EXT_W  = DATA_W + 1;
   localparam int unsigned PROD_W = 2 * EXT_W;
   localparam int unsigned NUM    = ACC_COUNT;

   if (ACC_W <= PROD_W) begin : g_bad_acc
      $error("ACC_W must exceed the product width to hold guard bits");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (NUM != 2) begin : g_bad_num
      $error("port list assumes two accumulators");
   end

   mac_op_e opc;
   assign opc = mac_op_e'(op);

   // holding register
   logic [DATA_W-1:0] t_q;
   always_ff @(posedge clk) begin
      if (!rst_n)             t_q <= '0;
      else if (opc == OP_LDT) t_q <= opa;
   end

   // operand widening
   logic [DATA_W-1:0] src_b;
   logic [EXT_W-1:0]  ext_a, ext_b;
   assign src_b = use_t ? t_q : opb;

   mac_operand_ext #(.IN_W(DATA_W)) u_ext_a (.din(opa),   .sgn(signed_mode), .dout(ext_a));
   mac_operand_ext #(.IN_W(DATA_W)) u_ext_b (.din(src_b), .sgn(signed_mode), .dout(ext_b));

   // multiplier
   logic signed [EXT_W-1:0]  mul_a, mul_b;
   logic signed [PROD_W-1:0] prod;
   assign mul_a = ext_a;
   assign mul_b = ext_b;

   mac_multiplier #(.EXT_W(EXT_W)) u_mul (.mcand(mul_a), .mplier(mul_b), .prod(prod));

   logic [ACC_W-1:0] prod_w, load_w;
   assign prod_w = ACC_W'(prod);
   assign load_w = ACC_W'(mul_a);

   // accumulator bank and shared adder
   logic [NUM-1:0][ACC_W-1:0] acc_q;
   logic [NUM-1:0]            ovf_q;
   logic [ACC_W-1:0]          acc_cur, sum_val, set_val;
   logic                      sum_ovf;
   acc_act_e                  act [NUM];

   assign acc_cur = acc_q[acc_sel];
   assign set_val = (opc == OP_LDA) ? load_w : prod_w;

   mac_acc_adder #(.W(ACC_W)) u_add (
      .base   (acc_cur),
      .addend (prod_w),
      .sub    (opc == OP_MSU),
      .sum    (sum_val),
      .ovf    (sum_ovf)
   );

   always_comb begin
      for (int i = 0; i < NUM; i++) begin
         act[i] = ACT_HOLD;
         if (int'(acc_sel) == i) begin
            unique case (opc)
               OP_CLR:         act[i] = ACT_ZERO;
               OP_MPY, OP_LDA: act[i] = ACT_SET;
               OP_MAC, OP_MSU: act[i] = ACT_SUM;
               default:        act[i] = ACT_HOLD;
            endcase
         end
      end
   end

   mac_acc_bank #(.ACC_W(ACC_W), .NUM(NUM)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .set_val (set_val),
      .sum_val (sum_val),
      .sum_ovf (sum_ovf),
      .acc_q   (acc_q),
      .ovf_q   (ovf_q)
   );

   assign acc_a = acc_q[0];
   assign acc_b = acc_q[1];
   assign ovf_a = ovf_q[0];
   assign ovf_b = ovf_q[1];

endmodule

// File: rtl/mac_checker.sv
module mac_checker
   import mac_pkg::*;
#(
   parameter int unsigned ACC_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       op,
   input logic             acc_sel,
   input logic [ACC_W-1:0] acc_a,
   input logic [ACC_W-1:0] acc_b,
   input logic             ovf_a,
   input logic             ovf_b
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R4
   unsel_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(acc_sel) == 1'b0) |-> ($stable(acc_b) && $stable(ovf_b)));

   // R4
   unsel_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(acc_sel) == 1'b1) |-> ($stable(acc_a) && $stable(ovf_a)));

   // R8
   clr_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(op) == OP_CLR && $past(acc_sel) == 1'b0) |-> (acc_a == '0 && !ovf_a));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(op) == OP_NOP || $past(op) == OP_IDLE || $past(op) == OP_LDT)
      |-> ($stable(acc_a) && $stable(acc_b) && $stable(ovf_a) && $stable(ovf_b)));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_a && !(op == OP_CLR && acc_sel == 1'b0)) |=> ovf_a);

endmodule

bind dual_acc_mac mac_checker #(.ACC_W(ACC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op      (op),
   .acc_sel (acc_sel),
   .acc_a   (acc_a),
   .acc_b   (acc_b),
   .ovf_a   (ovf_a),
   .ovf_b   (ovf_b)
);

// File: tb/sim_dual_acc_mac.sv
module sim_dual_acc_mac;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = 3'd0;
   logic        acc_sel = 1'b0;
   logic        signed_mode = 1'b0;
   logic        use_t = 1'b0;
   logic [15:0] opa = '0;
   logic [15:0] opb = '0;
   logic [39:0] acc_a, acc_b;
   logic        ovf_a, ovf_b;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_acc_mac u0 (
      .clk(clk), .rst_n(rst_n), .op(op), .acc_sel(acc_sel),
      .signed_mode(signed_mode), .use_t(use_t), .opa(opa), .opb(opb),
      .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
   );

   typedef struct {
      longint ea;
      longint eb;
      bit     oa;
      bit     ob;
      string  tag;
   } exp_t;

   exp_t   sb_q[$];
   longint ma = 0, mb = 0;
   bit     mfa = 0, mfb = 0;
   logic [15:0] mt = '0;

   function automatic longint wrap40(longint v);
      logic [39:0] w;
      w = v[39:0];
      return longint'($signed(w));
   endfunction

   function automatic longint widen(logic [15:0] v, bit s);
      if (s) return longint'($signed(v));
      return longint'(v);
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic do_op(logic [2:0] o, bit sel, bit sg, bit ut,
                        logic [15:0] a, logic [15:0] b, string tag);
      longint x, y, p, cur, s, nv;
      bit     nf;
      exp_t   it;
      @(negedge clk);
      op = o; acc_sel = sel; signed_mode = sg; use_t = ut; opa = a; opb = b;
      x = widen(a, sg);
      y = widen(ut ? mt : b, sg);
      p = x * y;
      cur = sel ? mb : ma;
      nf  = sel ? mfb : mfa;
      nv  = cur;
      case (o)
         3'd1: begin nv = 0; nf = 0; end
         3'd2: nv = p;
         3'd3: begin s = cur + p; nv = wrap40(s); if (s != nv) nf = 1; end
         3'd4: begin s = cur - p; nv = wrap40(s); if (s != nv) nf = 1; end
         3'd5: nv = x;
         3'd6: mt = a;
         default: ;
      endcase
      if (sel) begin mb = nv; mfb = nf; end
      else     begin ma = nv; mfa = nf; end
      it.ea = ma; it.eb = mb; it.oa = mfa; it.ob = mfb; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compares the item pushed before the edge just taken
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            chk(longint'($signed(acc_a)) == it.ea, it.tag, "acc_a", longint'($signed(acc_a)), it.ea);
            chk(longint'($signed(acc_b)) == it.eb, it.tag, "acc_b", longint'($signed(acc_b)), it.eb);
            chk(ovf_a == it.oa, it.tag, "ovf_a", longint'(ovf_a), longint'(it.oa));
            chk(ovf_b == it.ob, it.tag, "ovf_b", longint'(ovf_b), longint'(it.ob));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(acc_a == '0, "R1", "acc_a", longint'(acc_a), 0);
      chk(acc_b == '0, "R1", "acc_b", longint'(acc_b), 0);
      chk(!ovf_a && !ovf_b, "R1", "flags", longint'({ovf_a, ovf_b}), 0);
      rst_n = 1'b1;

      // R1 holding register is zero after reset
      do_op(3'd2, 0, 1, 1, 16'd1234, 16'd55, "R1_t_zero");
      // R6 load holding register, opb ignored while use_t
      do_op(3'd6, 1, 1, 0, 16'h0123, 16'h0, "R6_ldt");
      do_op(3'd2, 0, 1, 1, 16'd3, 16'h7777, "R6_use_t");
      // R2 / R3 signed multiply into second accumulator
      do_op(3'd2, 1, 1, 0, 16'hFFFE, 16'd3, "R2_mpy_neg");
      do_op(3'd2, 0, 0, 0, 16'hFFFE, 16'd3, "R3_unsigned");
      do_op(3'd2, 0, 1, 0, 16'h8000, 16'h8000, "R3_min_sq");
      do_op(3'd2, 0, 0, 0, 16'hFFFF, 16'hFFFF, "R3_max_unsigned");
      // R4 multiply-add, other accumulator untouched
      do_op(3'd3, 0, 1, 0, 16'h1234, 16'hFF00, "R4_mac1");
      do_op(3'd3, 0, 1, 0, 16'h7FFF, 16'h7FFF, "R4_mac2");
      do_op(3'd3, 1, 1, 0, 16'hFFFF, 16'hFFFF, "R4_mac_b");
      // R5 multiply-subtract
      do_op(3'd4, 1, 1, 0, 16'd100, 16'd100, "R5_msu_b");
      do_op(3'd4, 0, 0, 0, 16'hFFFF, 16'h0002, "R5_msu_a");
      // R7 load accumulator
      do_op(3'd5, 0, 1, 0, 16'h8001, 16'h0, "R7_lda_signed");
      do_op(3'd5, 1, 0, 0, 16'h8001, 16'h0, "R7_lda_unsigned");
      // R10 idle codes
      do_op(3'd0, 0, 1, 1, 16'hAAAA, 16'h5555, "R10_nop0");
      do_op(3'd7, 1, 1, 0, 16'hAAAA, 16'h5555, "R10_nop7");
      // R8 clear
      do_op(3'd1, 1, 0, 0, 16'h0, 16'h0, "R8_clr_b");
      do_op(3'd1, 0, 0, 0, 16'h0, 16'h0, "R8_clr_a");
      // R9 positive overflow after the 129th full-scale unsigned product
      for (int k = 0; k < 131; k++)
         do_op(3'd3, 0, 0, 0, 16'hFFFF, 16'hFFFF, "R9_pos_ovf");
      do_op(3'd0, 0, 0, 0, 16'h0, 16'h0, "R9_sticky_idle");
      do_op(3'd2, 0, 1, 0, 16'd2, 16'd2, "R9_sticky_mpy");
      do_op(3'd1, 0, 0, 0, 16'h0, 16'h0, "R8_clr_ovf");
      // R9 negative overflow on the second accumulator
      for (int k = 0; k < 131; k++)
         do_op(3'd4, 1, 0, 0, 16'hFFFF, 16'hFFFF, "R9_neg_ovf");
      do_op(3'd1, 1, 0, 0, 16'h0, 16'h0, "R8_clr_ovf_b");
      do_op(3'd0, 0, 0, 0, 16'h0, 16'h0, "R10_final");
      repeat (3) @(posedge clk);
      #2;
      chk(sb_q.size() == 0, "R10", "queue", longint'(sb_q.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule